// File: doc/BRIEF.md
# Flash Page March Test Controller

This block runs a fixed five-element march memory test over a flash array made of pages of bytes, 256 pages of 128 bytes by default. It drives the array through a simple command port: it raises a one-cycle command strobe with an operation (page erase, byte write or byte read), an address and write data, then waits for the response strobe. The response carries a failure flag and, for reads, the data read back.

Each march element is a short list of operations followed by a walk direction. The controller walks the pages in that direction. On each page it applies every operation of the element in turn, and each operation sweeps all bytes of the page in the same direction. Flash cannot be rewritten in place, so every write operation starts by erasing the whole current page. A rejected byte write is retried a bounded number of times. A read mismatch or an erase failure ends the run at once.

When the run ends the block raises `done`, together with `pass` when every element completed cleanly. After a failure it holds a record that locates the fault: element, operation slot, page, byte index, address, expected byte and the kind of command that failed. A status output follows bit 0 of the current page, so a lamp driven from it toggles as the walk advances.

Top module: `flash_march_tester`

## Requirements
- R1: Each command is one cycle of `cmdStart`, with `cmdOp` (0 = page erase, 1 = byte write, 2 = byte read), `cmdAddr` and `cmdWdata` valid in that cycle. No new command starts until `cmdDone` has answered the previous one. A byte address is page*PAGE_BYTES + index, and an erase uses the address of byte 0 of the page.
- R2: The elements run in this order, with 0 meaning byte 0x00 and 1 meaning byte 0xFF: E0 = {w0} up; E1 = {r0, w1, r1, w0, r0, w1} up; E2 = {r1, w0, w1} up; E3 = {r1, w0, w1, w0} down; E4 = {r0, w1, w0} down.
- R3: An up element walks pages 0 to NUM_PAGES-1 and bytes 0 to PAGE_BYTES-1. A down element walks both in reverse. All operations of an element are finished on one page before the next page starts, and an operation list ends at its first empty slot.
- R4: Each write operation is preceded by one erase of the current page. Reads and the individual byte writes are not preceded by an erase.
- R5: A byte write answered with `cmdFail` is reissued to the same byte, up to 4 retries. The fifth consecutive rejection of one byte ends the run with a failure. A successful write clears the retry count.
- R6: A read whose data differs from the expected byte ends the run immediately, and no further command is issued.
- R7: An erase answered with `cmdFail` ends the run with a failure, and no further command is issued.
- R8: On failure the block records the element number (0-based), the operation slot (0-based), the page, the byte index, the address, the expected byte and the failing command code (same encoding as `cmdOp`). For an erase, the index is the first index of the walk and the address is the page base. The record stays stable until the next start.
- R9: `pageLed` equals bit 0 of the page being addressed whenever a command is issued.
- R10: `busy` is high from the cycle after `start` until the run ends. `done` then stays high until the next start. `pass` is high only with `done`, and only after all five elements completed with no failure.
- R11: After reset `busy`, `done`, `pass` and `cmdStart` are low, and no command is issued while not busy. A `start` pulse during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test run (one-cycle pulse) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run ended; held until next start |
| pass | output | 1 | Run ended with no failure |
| cmdStart | output | 1 | Command strobe, one cycle |
| cmdOp | output | 2 | 0 erase, 1 write, 2 read |
| cmdAddr | output | ADDR_W | Byte address (page base for erase) |
| cmdWdata | output | 8 | Write data |
| cmdDone | input | 1 | Command response strobe |
| cmdFail | input | 1 | Response: command rejected |
| cmdRdata | input | 8 | Response: read data |
| pageLed | output | 1 | Bit 0 of the current page |
| failElem | output | 3 | Failing element number |
| failSlot | output | 3 | Failing operation slot |
| failKind | output | 2 | Failing command code |
| failPage | output | PAGE_W | Failing page |
| failIndex | output | IDX_W | Failing byte index |
| failAddr | output | ADDR_W | Failing address |
| failExpect | output | 8 | Expected byte of the failing operation |

## Verification
A wrong page, index, slot or element counter shows up at the next command strobe as an address or operation that differs from the march order. The bench's flash stub compares every command with an independently built expected sequence, so such a fault is visible within one command of the divergence. A retry counter that is off by one changes the number of attempts seen on a faulted byte, and this shows when the run ends. A wrong capture or end condition shows in the failure record and in `done`/`pass` in the cycle after the deciding response, along with any command that still appears after the abort.

// File: rtl/march_pkg.sv
package march_pkg;

  localparam int NUM_ELEMS = 5;
  localparam int SLOTS_PER_ELEM = 6;
  localparam int ELEM_W = 3;
  localparam int SLOT_W = 3;

  localparam logic [1:0] CMD_ERASE = 2'd0;
  localparam logic [1:0] CMD_WRITE = 2'd1;
  localparam logic [1:0] CMD_READ  = 2'd2;

  typedef struct packed {
    logic used;
    logic isWrite;
    logic value;
  } opSlot_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       initRun;
    logic       loadIndex;
    logic       stepIndex;
    logic       nextOp;
    logic       nextPage;
    logic       nextElem;
    logic       retryInc;
    logic       retryClr;
    logic       capture;
    logic [1:0] capKind;
    logic [7:0] capExpect;
  } dpCtl_t;

  // Operation table: octal key = {element, slot}
  function automatic opSlot_t slotOf(logic [ELEM_W-1:0] elem, logic [SLOT_W-1:0] slot);
    opSlot_t s;
    s = '0;
    case ({elem, slot})
      6'o00: s = '{1'b1, 1'b1, 1'b0};
      6'o10: s = '{1'b1, 1'b0, 1'b0};
      6'o11: s = '{1'b1, 1'b1, 1'b1};
      6'o12: s = '{1'b1, 1'b0, 1'b1};
      6'o13: s = '{1'b1, 1'b1, 1'b0};
      6'o14: s = '{1'b1, 1'b0, 1'b0};
      6'o15: s = '{1'b1, 1'b1, 1'b1};
      6'o20: s = '{1'b1, 1'b0, 1'b1};
      6'o21: s = '{1'b1, 1'b1, 1'b0};
      6'o22: s = '{1'b1, 1'b1, 1'b1};
      6'o30: s = '{1'b1, 1'b0, 1'b1};
      6'o31: s = '{1'b1, 1'b1, 1'b0};
      6'o32: s = '{1'b1, 1'b1, 1'b1};
      6'o33: s = '{1'b1, 1'b1, 1'b0};
      6'o40: s = '{1'b1, 1'b0, 1'b0};
      6'o41: s = '{1'b1, 1'b1, 1'b1};
      6'o42: s = '{1'b1, 1'b1, 1'b0};
      default: s = '0;
    endcase
    return s;
  endfunction

  function automatic logic elemDown(logic [ELEM_W-1:0] elem);
    return (elem == 3'd3) || (elem == 3'd4);
  endfunction

endpackage

// File: rtl/march_dp.sv
module march_dp
  import march_pkg::*;
#(
  parameter int NUM_PAGES = 256,
  parameter int PAGE_BYTES = 128,
  parameter int MAX_RETRIES = 4,
  localparam int PAGE_W = $clog2(NUM_PAGES),
  localparam int IDX_W = $clog2(PAGE_BYTES),
  localparam int ADDR_W = PAGE_W + IDX_W,
  localparam int RETRY_W = $clog2(MAX_RETRIES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  output logic [ELEM_W-1:0] elemQ,
  output logic [SLOT_W-1:0] slotQ,
  output logic [PAGE_W-1:0] pageQ,
  output logic [IDX_W-1:0]  indexQ,
  output logic              pageLast,
  output logic              indexLast,
  output logic              retryExhausted,
  output logic [ELEM_W-1:0] failElem,
  output logic [SLOT_W-1:0] failSlot,
  output logic [1:0]        failKind,
  output logic [PAGE_W-1:0] failPage,
  output logic [IDX_W-1:0]  failIndex,
  output logic [ADDR_W-1:0] failAddr,
  output logic [7:0]        failExpect
);

  localparam logic [PAGE_W-1:0]  PAGE_TOP  = PAGE_W'(NUM_PAGES - 1);
  localparam logic [IDX_W-1:0]   IDX_TOP   = IDX_W'(PAGE_BYTES - 1);
  localparam logic [RETRY_W-1:0] RETRY_TOP = RETRY_W'(MAX_RETRIES);

  logic [RETRY_W-1:0] retryQ;
  logic               down;
  logic               nextDown;

  assign down           = elemDown(elemQ);
  assign nextDown       = elemDown(elemQ + ELEM_W'(1));
  assign pageLast       = down ? (pageQ == '0) : (pageQ == PAGE_TOP);
  assign indexLast      = down ? (indexQ == '0) : (indexQ == IDX_TOP);
  assign retryExhausted = (retryQ == RETRY_TOP);

  // Element, slot and page walk
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      elemQ <= '0;
      slotQ <= '0;
      pageQ <= '0;
    end else if (ctl.initRun) begin
      elemQ <= '0;
      slotQ <= '0;
      pageQ <= '0;
    end else if (ctl.nextElem) begin
      elemQ <= elemQ + ELEM_W'(1);
      slotQ <= '0;
      pageQ <= nextDown ? PAGE_TOP : '0;
    end else if (ctl.nextPage) begin
      slotQ <= '0;
      pageQ <= down ? pageQ - PAGE_W'(1) : pageQ + PAGE_W'(1);
    end else if (ctl.nextOp) begin
      slotQ <= slotQ + SLOT_W'(1);
    end
  end

  // Byte index walk
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      indexQ <= '0;
    end else if (ctl.initRun) begin
      indexQ <= '0;
    end else if (ctl.loadIndex) begin
      indexQ <= down ? IDX_TOP : '0;
    end else if (ctl.stepIndex) begin
      indexQ <= down ? indexQ - IDX_W'(1) : indexQ + IDX_W'(1);
    end
  end

  // Write retry count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retryQ <= '0;
    end else if (ctl.initRun || ctl.retryClr) begin
      retryQ <= '0;
    end else if (ctl.retryInc) begin
      retryQ <= retryQ + RETRY_W'(1);
    end
  end

  // Failure record
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failElem   <= '0;
      failSlot   <= '0;
      failKind   <= '0;
      failPage   <= '0;
      failIndex  <= '0;
      failAddr   <= '0;
      failExpect <= '0;
    end else if (ctl.initRun) begin
      failElem   <= '0;
      failSlot   <= '0;
      failKind   <= '0;
      failPage   <= '0;
      failIndex  <= '0;
      failAddr   <= '0;
      failExpect <= '0;
    end else if (ctl.capture) begin
      failElem   <= elemQ;
      failSlot   <= slotQ;
      failKind   <= ctl.capKind;
      failPage   <= pageQ;
      failIndex  <= indexQ;
      failAddr   <= (ctl.capKind == CMD_ERASE) ? {pageQ, IDX_W'(0)} : {pageQ, indexQ};
      failExpect <= ctl.capExpect;
    end
  end

  // R5: retry count never passes its limit
  a_r5_retry_bound: assert property (@(posedge clk) disable iff (!rstN)
    retryQ <= RETRY_TOP);

endmodule

// File: rtl/march_ctrl.sv
module march_ctrl
  import march_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ELEM_W-1:0] elem,
  input  logic [SLOT_W-1:0] slot,
  input  logic              pageLast,
  input  logic              indexLast,
  input  logic              retryExhausted,
  input  logic              cmdDone,
  input  logic              cmdFail,
  input  logic [7:0]        cmdRdata,
  output dpCtl_t            ctl,
  output logic              cmdStart,
  output logic [1:0]        cmdOp,
  output logic [7:0]        cmdWdata,
  output logic              busy,
  output logic              done,
  output logic              pass
);

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_ERASE, S_EWAIT, S_ISSUE, S_BWAIT
  } state_e;

  state_e  stateQ, stateD;
  opSlot_t cur;
  logic [7:0] expByte;
  logic    finPass, finFail;

  assign cur     = slotOf(elem, slot);
  assign expByte = cur.value ? 8'hFF : 8'h00;

  always_comb begin
    stateD        = stateQ;
    ctl           = '0;
    ctl.capExpect = expByte;
    finPass       = 1'b0;
    finFail       = 1'b0;
    case (stateQ)
      S_IDLE: begin
        if (start) begin
          ctl.initRun = 1'b1;
          stateD      = S_FETCH;
        end
      end
      S_FETCH: begin
        if (!cur.used) begin
          if (!pageLast) begin
            ctl.nextPage = 1'b1;
          end else if (elem == ELEM_W'(NUM_ELEMS - 1)) begin
            finPass = 1'b1;
            stateD  = S_IDLE;
          end else begin
            ctl.nextElem = 1'b1;
          end
        end else begin
          ctl.loadIndex = 1'b1;
          ctl.retryClr  = 1'b1;
          stateD        = cur.isWrite ? S_ERASE : S_ISSUE;
        end
      end
      S_ERASE: stateD = S_EWAIT;
      S_EWAIT: begin
        if (cmdDone) begin
          if (cmdFail) begin
            ctl.capture = 1'b1;
            ctl.capKind = CMD_ERASE;
            finFail     = 1'b1;
            stateD      = S_IDLE;
          end else begin
            stateD = S_ISSUE;
          end
        end
      end
      S_ISSUE: stateD = S_BWAIT;
      S_BWAIT: begin
        if (cmdDone) begin
          if (cur.isWrite && cmdFail) begin
            if (retryExhausted) begin
              ctl.capture = 1'b1;
              ctl.capKind = CMD_WRITE;
              finFail     = 1'b1;
              stateD      = S_IDLE;
            end else begin
              ctl.retryInc = 1'b1;
              stateD       = S_ISSUE;
            end
          end else if (!cur.isWrite && (cmdRdata != expByte)) begin
            ctl.capture = 1'b1;
            ctl.capKind = CMD_READ;
            finFail     = 1'b1;
            stateD      = S_IDLE;
          end else begin
            ctl.retryClr = 1'b1;
            if (indexLast) begin
              ctl.nextOp = 1'b1;
              stateD     = S_FETCH;
            end else begin
              ctl.stepIndex = 1'b1;
              stateD        = S_ISSUE;
            end
          end
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      done   <= 1'b0;
      pass   <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (ctl.initRun) begin
        done <= 1'b0;
        pass <= 1'b0;
      end else if (finPass) begin
        done <= 1'b1;
        pass <= 1'b1;
      end else if (finFail) begin
        done <= 1'b1;
        pass <= 1'b0;
      end
    end
  end

  assign busy     = (stateQ != S_IDLE);
  assign cmdStart = (stateQ == S_ERASE) || (stateQ == S_ISSUE);
  assign cmdOp    = (stateQ == S_ERASE) ? CMD_ERASE : (cur.isWrite ? CMD_WRITE : CMD_READ);
  assign cmdWdata = (stateQ == S_ISSUE && cur.isWrite) ? expByte : 8'h00;

  // R1: command strobe lasts a single cycle
  a_r1_start_single: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> !cmdStart);

  // R11: no command while idle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !cmdStart);

  // R10: pass only together with done
  a_r10_pass_needs_done: assert property (@(posedge clk) disable iff (!rstN)
    pass |-> done);

endmodule

// File: rtl/flash_march_tester.sv
module flash_march_tester
  import march_pkg::*;
#(
  parameter int NUM_PAGES = 256,
  parameter int PAGE_BYTES = 128,
  parameter int MAX_RETRIES = 4,
  localparam int PAGE_W = $clog2(NUM_PAGES),
  localparam int IDX_W = $clog2(PAGE_BYTES),
  localparam int ADDR_W = PAGE_W + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              cmdStart,
  output logic [1:0]        cmdOp,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [7:0]        cmdWdata,
  input  logic              cmdDone,
  input  logic              cmdFail,
  input  logic [7:0]        cmdRdata,
  output logic              pageLed,
  output logic [2:0]        failElem,
  output logic [2:0]        failSlot,
  output logic [1:0]        failKind,
  output logic [PAGE_W-1:0] failPage,
  output logic [IDX_W-1:0]  failIndex,
  output logic [ADDR_W-1:0] failAddr,
  output logic [7:0]        failExpect
);

  dpCtl_t            ctl;
  logic [ELEM_W-1:0] elemQ;
  logic [SLOT_W-1:0] slotQ;
  logic [PAGE_W-1:0] pageQ;
  logic [IDX_W-1:0]  indexQ;
  logic              pageLast, indexLast, retryExhausted;

  march_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start),
    .elem(elemQ), .slot(slotQ),
    .pageLast(pageLast), .indexLast(indexLast), .retryExhausted(retryExhausted),
    .cmdDone(cmdDone), .cmdFail(cmdFail), .cmdRdata(cmdRdata),
    .ctl(ctl), .cmdStart(cmdStart), .cmdOp(cmdOp), .cmdWdata(cmdWdata),
    .busy(busy), .done(done), .pass(pass)
  );

  march_dp #(
    .NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES), .MAX_RETRIES(MAX_RETRIES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .elemQ(elemQ), .slotQ(slotQ), .pageQ(pageQ), .indexQ(indexQ),
    .pageLast(pageLast), .indexLast(indexLast), .retryExhausted(retryExhausted),
    .failElem(failElem), .failSlot(failSlot), .failKind(failKind),
    .failPage(failPage), .failIndex(failIndex), .failAddr(failAddr),
    .failExpect(failExpect)
  );

  assign cmdAddr = (cmdOp == CMD_ERASE) ? {pageQ, IDX_W'(0)} : {pageQ, indexQ};
  assign pageLed = pageQ[0];

  // R8: failure record holds while the ended run waits for a new start
  a_r8_record_hold: assert property (@(posedge clk) disable iff (!rstN)
    (done && !pass && !start) |=> ($stable(failAddr) && $stable(failExpect) && $stable(failKind)));

endmodule

// File: tb/flash_march_tester_tb.sv
`timescale 1ns/1ps
module flash_march_tester_tb_top;

  localparam int NP = 4;
  localparam int PB = 8;
  localparam int PAGE_W = 2;
  localparam int IDX_W = 3;
  localparam int ADDR_W = 5;
  localparam int FULL_CMDS = 17 * PB * NP + 11 * NP;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic busy, done, pass, cmdStart, pageLed;
  logic [1:0] cmdOp;
  logic [ADDR_W-1:0] cmdAddr;
  logic [7:0] cmdWdata;
  logic cmdDone = 1'b0;
  logic cmdFail = 1'b0;
  logic [7:0] cmdRdata = 8'h00;
  logic [2:0] failElem, failSlot;
  logic [1:0] failKind;
  logic [PAGE_W-1:0] failPage;
  logic [IDX_W-1:0] failIndex;
  logic [ADDR_W-1:0] failAddr;
  logic [7:0] failExpect;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_march_tester #(.NUM_PAGES(NP), .PAGE_BYTES(PB), .MAX_RETRIES(4)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done), .pass(pass),
    .cmdStart(cmdStart), .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdWdata(cmdWdata),
    .cmdDone(cmdDone), .cmdFail(cmdFail), .cmdRdata(cmdRdata), .pageLed(pageLed),
    .failElem(failElem), .failSlot(failSlot), .failKind(failKind), .failPage(failPage),
    .failIndex(failIndex), .failAddr(failAddr), .failExpect(failExpect)
  );

  // op codes: 0 empty, 1 w0, 2 w1, 3 r0, 4 r1
  int march [5][6] = '{
    '{1, 0, 0, 0, 0, 0},
    '{3, 2, 4, 1, 3, 2},
    '{4, 1, 2, 0, 0, 0},
    '{4, 1, 2, 1, 0, 0},
    '{3, 2, 1, 0, 0, 0}
  };

  int qOp[$];
  int qAddr[$];
  int qData[$];

  logic [7:0] mem [NP*PB];
  int cmdCount, eraseCount, seqErr, ledErr, lateCmd;
  int failErasePage, wrFailAddr, wrFailLeft, wrAttempts;
  int stuckAddr;
  logic [7:0] stuck0, stuck1;
  logic respPending = 1'b0;
  int respCnt;
  logic pendFail;
  logic [7:0] pendData;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic buildExpect();
    qOp.delete(); qAddr.delete(); qData.delete();
    for (int e = 0; e < 5; e++) begin
      for (int pi = 0; pi < NP; pi++) begin
        int p;
        p = (e >= 3) ? NP - 1 - pi : pi;
        for (int s = 0; s < 6; s++) begin
          int op;
          op = march[e][s];
          if (op == 0) break;
          if (op <= 2) begin
            qOp.push_back(0); qAddr.push_back(p * PB); qData.push_back(0);
          end
          for (int ii = 0; ii < PB; ii++) begin
            int i;
            i = (e >= 3) ? PB - 1 - ii : ii;
            qOp.push_back(op <= 2 ? 1 : 2);
            qAddr.push_back(p * PB + i);
            qData.push_back((op == 2 || op == 4) ? 255 : 0);
          end
        end
      end
    end
  endtask

  task automatic clearKnobs();
    cmdCount = 0; eraseCount = 0; seqErr = 0; ledErr = 0; lateCmd = 0;
    failErasePage = -1; wrFailAddr = -1; wrFailLeft = 0; wrAttempts = 0;
    stuckAddr = -1; stuck0 = 8'h00; stuck1 = 8'h00;
  endtask

  // Flash stub: responds two cycles after each command strobe
  always @(negedge clk) begin
    if (respPending) begin
      if (respCnt == 0) begin
        cmdDone = 1'b1; cmdFail = pendFail; cmdRdata = pendData; respPending = 1'b0;
      end else begin
        respCnt--;
      end
    end else begin
      cmdDone = 1'b0; cmdFail = 1'b0;
    end
    if (cmdStart === 1'b1) begin
      int a, op;
      logic f;
      logic [7:0] rd;
      a = int'(cmdAddr); op = int'(cmdOp); f = 1'b0; rd = 8'h00;
      cmdCount++;
      if (done) lateCmd++;
      if (pageLed !== cmdAddr[IDX_W]) ledErr++;
      if (qOp.size() == 0) seqErr++;
      else if (qOp[0] != op || qAddr[0] != a || (op == 1 && qData[0] != int'(cmdWdata))) begin
        if (seqErr == 0)
          $display("  sequence diverges at command %0d: op %0d addr %0d (expected op %0d addr %0d)",
                   cmdCount, op, a, qOp[0], qAddr[0]);
        seqErr++;
      end
      if (op == 0) begin
        eraseCount++;
        if (a / PB == failErasePage) f = 1'b1;
        else for (int k = 0; k < PB; k++) mem[(a / PB) * PB + k] = 8'hFF;
      end else if (op == 1) begin
        if (a == wrFailAddr) wrAttempts++;
        if (a == wrFailAddr && wrFailLeft > 0) begin
          f = 1'b1; wrFailLeft--;
        end else mem[a] = cmdWdata;
      end else begin
        rd = mem[a];
        if (a == stuckAddr) rd = (rd & ~stuck0) | stuck1;
      end
      if (!f && qOp.size() != 0) begin
        void'(qOp.pop_front()); void'(qAddr.pop_front()); void'(qData.pop_front());
      end
      pendFail = f; pendData = rd; respCnt = 1; respPending = 1'b1;
    end
  end

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitDone(input string tag);
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk); n++;
    end
    chk(tag, int'(done), 1);
  endtask

  task automatic runTest();
    buildExpect();
    pulseStart();
  endtask

  task automatic checkQuietAfter(input string tag);
    int c0;
    c0 = cmdCount;
    repeat (30) @(negedge clk);
    chk(tag, cmdCount, c0);
    chk({tag, " late"}, lateCmd, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11 reset busy", int'(busy), 0);
    chk("R11 reset done", int'(done), 0);
    chk("R11 reset pass", int'(pass), 0);
    chk("R11 reset cmdStart", int'(cmdStart), 0);
    repeat (10) @(negedge clk);
    chk("R11 no commands idle", cmdCount, 0);
  endtask

  task automatic t_full_pass();
    clearKnobs();
    runTest();
    chk("R10 busy after start", int'(busy), 1);
    chk("R10 done low in run", int'(done), 0);
    waitDone("R10 full run done");
    chk("R10 full run pass", int'(pass), 1);
    chk("R1 R2 R3 order", seqErr, 0);
    chk("R2 all commands", qOp.size(), 0);
    chk("R3 command count", cmdCount, FULL_CMDS);
    chk("R4 erase count", eraseCount, 11 * NP);
    chk("R9 page led", ledErr, 0);
    chk("R10 busy low at end", int'(busy), 0);
    checkQuietAfter("R11 quiet after pass");
  endtask

  task automatic t_start_ignored();
    clearKnobs();
    runTest();
    repeat (40) @(negedge clk);
    pulseStart();
    waitDone("R11 done with extra start");
    chk("R11 order kept", seqErr, 0);
    chk("R11 count kept", cmdCount, FULL_CMDS);
    chk("R11 pass", int'(pass), 1);
  endtask

  task automatic t_retry_ok();
    clearKnobs();
    wrFailAddr = 9; wrFailLeft = 4;
    runTest();
    waitDone("R5 retry run done");
    chk("R5 four retries pass", int'(pass), 1);
    chk("R5 attempts first write", wrAttempts >= 5 ? 1 : 0, 1);
    chk("R5 order with retries", seqErr, 0);
    chk("R5 count with retries", cmdCount, FULL_CMDS + 4);
  endtask

  task automatic t_retry_fail();
    clearKnobs();
    wrFailAddr = 9; wrFailLeft = 5;
    runTest();
    waitDone("R5 retry fail done");
    chk("R5 fifth reject fails", int'(pass), 0);
    chk("R5 attempts", wrAttempts, 5);
    chk("R8 kind write", int'(failKind), 1);
    chk("R8 elem", int'(failElem), 0);
    chk("R8 slot", int'(failSlot), 0);
    chk("R8 page", int'(failPage), 1);
    chk("R8 index", int'(failIndex), 1);
    chk("R8 addr", int'(failAddr), 9);
    chk("R8 expect", int'(failExpect), 0);
    checkQuietAfter("R8 quiet after write fail");
  endtask

  task automatic t_read_stuck1();
    clearKnobs();
    stuckAddr = 13; stuck1 = 8'h01;
    runTest();
    waitDone("R6 stuck1 done");
    chk("R6 stuck1 fails", int'(pass), 0);
    chk("R6 order before abort", seqErr, 0);
    chk("R8 kind read", int'(failKind), 2);
    chk("R8 elem r0", int'(failElem), 1);
    chk("R8 slot r0", int'(failSlot), 0);
    chk("R8 page r0", int'(failPage), 1);
    chk("R8 index r0", int'(failIndex), 5);
    chk("R8 addr r0", int'(failAddr), 13);
    chk("R8 expect r0", int'(failExpect), 0);
    checkQuietAfter("R6 quiet after mismatch");
  endtask

  task automatic t_read_stuck0();
    clearKnobs();
    stuckAddr = 22; stuck0 = 8'h80;
    runTest();
    waitDone("R6 stuck0 done");
    chk("R6 stuck0 fails", int'(pass), 0);
    chk("R8 elem r1", int'(failElem), 1);
    chk("R8 slot r1", int'(failSlot), 2);
    chk("R8 page r1", int'(failPage), 2);
    chk("R8 index r1", int'(failIndex), 6);
    chk("R8 expect r1", int'(failExpect), 255);
    checkQuietAfter("R6 quiet after r1 mismatch");
  endtask

  task automatic t_erase_fail();
    clearKnobs();
    failErasePage = 2;
    runTest();
    waitDone("R7 erase fail done");
    chk("R7 erase fail", int'(pass), 0);
    chk("R7 kind erase", int'(failKind), 0);
    chk("R7 elem", int'(failElem), 0);
    chk("R8 erase page", int'(failPage), 2);
    chk("R8 erase index", int'(failIndex), 0);
    chk("R8 erase addr", int'(failAddr), 16);
    checkQuietAfter("R7 quiet after erase fail");
  endtask

  initial begin
    for (int k = 0; k < NP * PB; k++) mem[k] = 8'h00;
    clearKnobs();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_full_pass();
    t_start_ignored();
    t_retry_ok();
    t_retry_fail();
    t_read_stuck1();
    t_read_stuck0();
    t_erase_fail();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule